// File: doc/BRIEF.md
# Eight-bit timer/counter with a switchable prescaler

This block is an 8-bit up-counter for a small controller. It advances on one of two sources. The first is the instruction-cycle enable, a one-clock pulse that arrives once every four system clocks. The second is a counting edge on an external pin, which is first brought into the clock domain by a synchronizer. Software reads and writes the count over a simple bus port. It sets the behaviour through a 6-bit option field, and it watches a sticky overflow flag whose interrupt request can be masked.

One 8-bit prescaler serves two users, and only one of them at a time. When it is given to the timer, the timer advances once every 2, 4, ... 256 source events. When it is given to the watchdog path, the timer counts every source event, and the watchdog tick output becomes a divided copy of the watchdog source. A write to the count register holds counting off for the next two instruction cycles. The sleep input stops the timer.

Top module: `tmr8_unit`

## Requirements
- R1: After reset, the count reads 0x00, the overflow flag is 0, the interrupt request is 0 and the watchdog tick is 0.
- R2: A write loads `wr_data_i` into the count, and `rd_data_o` shows that value from the next clock on.
- R3: With option bit 5 = 0 (internal source) and option bit 3 = 1 (prescaler owned by the watchdog), the count rises by one for each `instr_tick_i` pulse.
- R4: With option bit 5 = 1, the count follows the pin. Option bit 4 = 0 counts rising edges and option bit 4 = 1 counts falling edges. A pin change that is sampled at clock edge k shows up in the count after edge k+2.
- R5: After a write, the next two `instr_tick_i` pulses allow no increment from either source. A source event in the same cycle as a write is lost.
- R6: With option bit 3 = 0, the rate field in option bits 2:0, holding a value r, makes the timer advance once every 2^(r+1) accepted source events.
- R7: A write clears the prescaler when the prescaler belongs to the timer. It leaves the prescaler unchanged when the prescaler belongs to the watchdog.
- R8: An increment from 0xFF to 0x00 sets the overflow flag. The flag stays set until `flag_clr_i` is applied. If a wrap and a clear arrive in the same cycle, the flag is set.
- R9: `irq_o` is high exactly when the flag is set and `irq_en_i` is 1.
- R10: While `sleep_i` is 1, the count does not change except by a write, so no overflow can occur.
- R11: `wdg_tick_o` is registered and so lags by one clock. With option bit 3 = 0, it repeats `wdg_src_i`. With option bit 3 = 1, it pulses on every 2^(r+1)-th `wdg_src_i` pulse, and the prescaler then advances on `wdg_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_tick_i | input | 1 | One-clock pulse per instruction cycle |
| opt_i | input | 6 | Bit 5 selects the source, bit 4 selects the edge, bit 3 selects the prescaler owner, bits 2:0 hold the rate |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| sleep_i | input | 1 | Stops the timer |
| wr_en_i | input | 1 | Write strobe for the count |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current count |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the overflow flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| wdg_src_i | input | 1 | Watchdog source pulse |
| wdg_tick_o | output | 1 | Watchdog tick, direct or divided |

## Verification
The properties assume that `instr_tick_i` and `wdg_src_i` are single-clock pulses. They also assume that the option field changes only while the pin is steady and a write is not in progress, because a change of edge polarity alone can look like a counting edge. The bench follows these rules. It changes `opt_i` only between test phases, with the pin held low. It produces instruction ticks from a fixed phase counter. It toggles the pin at most once every three clocks, so every edge passes the two synchronizer stages before the next edge arrives.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} tmr_src_e;
  typedef enum logic {OWN_TIMER = 1'b0, OWN_WDG = 1'b1} psc_owner_e;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q, last_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], pin_i};
    last_d = sh_q[STAGES-1];
    edge_o = (sh_q[STAGES-1] ^ fall_i) & ~(last_q ^ fall_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int PSC_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] rate_i,
  output logic             tap_o
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W-1:0] full_lo;

  // full_lo[i] is set when psc bits i..0 are all ones
  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < PSC_W; i++) begin
      acc        = acc & psc_q[i];
      full_lo[i] = acc;
    end
    tap_o = full_lo[rate_i];
    if (clr_i)       psc_d = '0;
    else if (step_i) psc_d = psc_q + 1'b1;
    else             psc_d = psc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !tap_o);
endmodule

// File: rtl/tmr8_count_core.sv
module tmr8_count_core #(
  parameter int CNT_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             inc_i,
  input  logic             tick_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             inh_busy_o
);
  localparam int INH_W = $clog2(INH_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [INH_W-1:0] inh_q, inh_d;
  logic             flag_q, flag_d, wrap;

  always_comb begin
    wrap = inc_i & ~wr_en_i & (cnt_q == '1);
    if (wr_en_i)    cnt_d = wr_data_i;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
    if (wr_en_i)                      inh_d = INH_W'(INH_CYC);
    else if (tick_i && inh_q != '0)   inh_d = inh_q - 1'b1;
    else                              inh_d = inh_q;
    flag_d = wrap | (flag_q & ~flag_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      inh_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      inh_q  <= inh_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign flag_o     = flag_q;
  assign inh_busy_o = (inh_q != '0);

  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> cnt_o == $past(wr_data_i));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);
  a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == '1 && inc_i && !wr_en_i) |=> (flag_o && cnt_o == '0));
endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_tick_i,
  input  logic [SEL_W+2:0]     opt_i,
  input  logic                 ext_clk_i,
  input  logic                 sleep_i,
  input  logic                 wr_en_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  output logic [CNT_W-1:0]     rd_data_o,
  input  logic                 irq_en_i,
  input  logic                 flag_clr_i,
  output logic                 ovf_flag_o,
  output logic                 irq_o,
  input  logic                 wdg_src_i,
  output logic                 wdg_tick_o
);
  localparam int BIT_OWN  = SEL_W;
  localparam int BIT_EDGE = SEL_W + 1;
  localparam int BIT_SRC  = SEL_W + 2;

  tmr_src_e   src_sel;
  psc_owner_e owner;
  logic       pin_edge, raw_pulse, go, inh_busy;
  logic       psc_step, psc_clr, psc_tap, tmr_inc;
  logic       wdg_q, wdg_d, flag;

  assign src_sel = tmr_src_e'(opt_i[BIT_SRC]);
  assign owner   = psc_owner_e'(opt_i[BIT_OWN]);

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_clk_i),
    .fall_i (opt_i[BIT_EDGE]),
    .edge_o (pin_edge)
  );

  always_comb begin
    raw_pulse = (src_sel == SRC_PIN) ? pin_edge : instr_tick_i;
    go        = raw_pulse & ~sleep_i & ~wr_en_i & ~inh_busy;
    if (owner == OWN_WDG) begin
      psc_step = wdg_src_i;
      psc_clr  = 1'b0;
      tmr_inc  = go;
      wdg_d    = wdg_src_i & psc_tap;
    end else begin
      psc_step = go;
      psc_clr  = wr_en_i;
      tmr_inc  = go & psc_tap;
      wdg_d    = wdg_src_i;
    end
  end

  tmr8_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) i_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (psc_clr),
    .step_i (psc_step),
    .rate_i (opt_i[SEL_W-1:0]),
    .tap_o  (psc_tap)
  );

  tmr8_count_core #(.CNT_W(CNT_W), .INH_CYC(INH_CYC)) i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .inc_i      (tmr_inc),
    .tick_i     (instr_tick_i),
    .flag_clr_i (flag_clr_i),
    .cnt_o      (rd_data_o),
    .flag_o     (flag),
    .inh_busy_o (inh_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdg_q <= 1'b0;
    else        wdg_q <= wdg_d;
  end

  assign wdg_tick_o = wdg_q;
  assign ovf_flag_o = flag;
  assign irq_o      = flag & irq_en_i;

  a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !wr_en_i) |=> $stable(rd_data_o));
  a_r11_tick_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_tick_o |-> $past(wdg_src_i));
endmodule

// File: tb/test_tmr8_unit.sv
module test_tmr8_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_tick, ext_clk, sleep, wr_en, irq_en, flag_clr, wdg_src;
  logic [5:0] opt;
  logic [7:0] wr_data, rd_data;
  logic       ovf_flag, irq, wdg_tick;

  int    n_checks = 0, n_errors = 0, ph = 0, wdg_period = 0;
  string cur_req = "R1";
  int    m_cnt, m_flag, m_inh, m_psc, m_s1, m_s2, m_prev, m_wdg;

  always #5 clk = ~clk;

  tmr8_unit i_tmr8_unit (
    .clk(clk), .rst_n(rst_n), .instr_tick_i(instr_tick), .opt_i(opt),
    .ext_clk_i(ext_clk), .sleep_i(sleep), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
    .ovf_flag_o(ovf_flag), .irq_o(irq), .wdg_src_i(wdg_src), .wdg_tick_o(wdg_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at ph=%0d", req, act, exp, ph);
    end
  endtask

  // behavioural reference, one call per rising clock edge
  task automatic model_step();
    int  r, span, es, edge_now, src, go, tinc, full;
    r = opt[2:0]; span = 1 << (r + 1); es = opt[4];
    edge_now = ((m_s2 ^ es) == 1) && ((m_prev ^ es) == 0);
    src = opt[5] ? edge_now : instr_tick;
    go  = src && !sleep && (m_inh == 0) && !wr_en;
    full = ((m_psc % span) == span - 1);
    if (opt[3] == 0) begin
      tinc  = go && full;
      if (go) m_psc = (m_psc + 1) % 256;
      m_wdg = wdg_src;
    end else begin
      tinc  = go;
      m_wdg = wdg_src && full;
      if (wdg_src) m_psc = (m_psc + 1) % 256;
    end
    if (wr_en) begin
      m_cnt = wr_data; m_inh = 2;
      if (opt[3] == 0) m_psc = 0;
    end else begin
      if (instr_tick && m_inh > 0) m_inh--;
      if (tinc) begin
        if (m_cnt == 255) begin m_cnt = 0; m_flag = 1; end
        else m_cnt++;
      end else if (flag_clr) m_flag = 0;
      if (tinc && m_cnt != 0 && flag_clr) m_flag = 0;
    end
    if (wr_en && flag_clr) m_flag = 0;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
  endtask

  task automatic compare();
    check(rd_data == 8'(m_cnt), {cur_req, " count"}, rd_data, m_cnt);
    check(ovf_flag == m_flag[0], {cur_req, " R8 flag"}, ovf_flag, m_flag);
    check(irq == (m_flag[0] & irq_en), {cur_req, " R9 irq"}, irq, m_flag[0] & irq_en);
    check(wdg_tick == m_wdg[0], {cur_req, " R11 wdg"}, wdg_tick, m_wdg);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    ph++;
    instr_tick = (ph % 4 == 3);
    wdg_src    = (wdg_period != 0) && (ph % wdg_period == 0);
    wr_en = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic write_cnt(input int v);
    wr_en = 1'b1; wr_data = 8'(v); cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_tick = 0; ext_clk = 0; sleep = 0; wr_en = 0;
    irq_en = 0; flag_clr = 0; wdg_src = 0; opt = 6'b001000; wr_data = 0;
    m_cnt = 0; m_flag = 0; m_inh = 0; m_psc = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_wdg = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_data == 0 && !ovf_flag && !irq && !wdg_tick, "R1 reset", rd_data, 0);
    rst_n = 1'b1;
    cur_req = "R1"; run(2);

    cur_req = "R2"; write_cnt(8'h5A);
    check(rd_data == 8'h5A, "R2 readback", rd_data, 8'h5A);
    cur_req = "R5"; run(12);
    cur_req = "R3"; run(40);
    check(rd_data == 8'(m_cnt) && m_cnt > 8'h5A, "R3 advanced", rd_data, m_cnt);

    // overflow and sticky flag
    cur_req = "R8"; irq_en = 1; write_cnt(8'hF8); run(60);
    check(ovf_flag == 1, "R8 set after wrap", ovf_flag, 1);
    check(irq == 1, "R9 irq with enable", irq, 1);
    irq_en = 0; run(3);
    cur_req = "R9"; check(irq == 0, "R9 masked", irq, 0);
    flag_clr = 1; cyc(); run(3);
    check(ovf_flag == 0, "R8 cleared", ovf_flag, 0);

    // prescaler to timer, various rates, with writes that clear it (R7)
    for (int r = 0; r < 8; r += 3) begin
      cur_req = "R6"; opt = 6'(r); run(2);
      cur_req = "R7"; write_cnt(8'h10);
      cur_req = "R6"; run(r == 6 ? 1100 : 300);
    end
    opt = 6'b000111; cur_req = "R6"; write_cnt(0); run(2200);
    check(rd_data == 8'(m_cnt) && m_cnt >= 1, "R6 rate 7", rd_data, m_cnt);

    // sleep
    opt = 6'b001000; cur_req = "R10"; write_cnt(8'hFE); run(4);
    sleep = 1; run(80);
    check(ovf_flag == 0 && rd_data == 8'hFE, "R10 frozen", rd_data, 8'hFE);
    sleep = 0; run(20);

    // external pin, rising then falling
    for (int es = 0; es < 2; es++) begin
      ext_clk = 0; opt = {1'b1, 1'(es), 4'b1000}; run(4);
      cur_req = "R4"; write_cnt(0); run(10);
      for (int k = 0; k < 30; k++) begin ext_clk = ~ext_clk; run(3); end
      ext_clk = 0; run(6);
      check(rd_data == 8'(m_cnt), "R4 pin count", rd_data, m_cnt);
    end
    // inhibit with pin edges
    cur_req = "R5"; write_cnt(8'h40);
    for (int k = 0; k < 6; k++) begin ext_clk = ~ext_clk; run(3); end

    // watchdog path both ways
    ext_clk = 0; opt = 6'b000010; wdg_period = 3; cur_req = "R11"; run(60);
    opt = 6'b001001; run(120);
    cur_req = "R7"; write_cnt(8'h01); run(60);
    wdg_period = 0; run(5);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule